// File: doc/BRIEF.md
# Serial lane byte receiver

This block sits on one output lane of a bit-serial packet switch. The lane has three wires: a data bit, an active-low valid strobe and an active-low frame strobe. The block finds the packets on the lane and collects their payload bits into bytes, least significant bit first. It delivers each byte on a byte-wide interface with a one-cycle valid pulse and marks the byte that holds the final bit of the packet. If a packet ends partway through a byte, that byte is delivered padded with zeros and flagged as a length error. A saturating count of the bytes delivered in the current packet stays readable after the packet ends.

On the lane, a bit is data when both strobes are low. The frame strobe goes low on the first cycle of a packet and goes high on the same cycle as the final bit, so the final bit arrives with frame high and valid low. Cycles inside a packet with valid high carry no data. Frame stays high for at least one cycle between packets.

A small state machine follows the lane. Its states are ST_ARMED (after reset, waiting to see frame high), ST_IDLE (between packets) and ST_RECV (inside a packet). Its transitions are:
- ARMED→IDLE when frame is high.
- IDLE→RECV on a start cycle, which is frame low.
- RECV→IDLE on the end cycle, which is frame high.
- Every other case holds the current state.

Top module: `lane_byte_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), all outputs become zero at that edge and stay zero on the first cycle after release.
- R2: Inside a packet, a cycle with `lane_frm_n`=0 and `lane_vld_n`=0 accepts `lane_bit`. The first accepted bit of a byte becomes `byte_data[0]`, the next becomes bit 1, and so on up to bit 7.
- R3: The end cycle (`lane_frm_n`=1 while in a packet) with `lane_vld_n`=0 supplies the final bit, and this bit is accepted.
- R4: When a byte has its eighth bit, `byte_vld` is high for exactly one cycle, registered one clock after the cycle that carried that bit. `byte_last`=1 only on the byte that holds the packet's final bit.
- R5: Inside a packet, cycles with `lane_vld_n`=1 add no bit and do not change the bit position.
- R6: If a packet ends with 1 to 7 bits pending, those bits are delivered one clock after the end cycle, zero-extended in the upper bits, with `byte_last`=1 and `byte_len_err`=1. A full final byte has `byte_len_err`=0.
- R7: After reset, the lane is ignored until `lane_frm_n`=1 has been seen, even if the lane is in the middle of a packet when reset is released.
- R8: Between packets (`lane_frm_n`=1), the lane is ignored whatever `lane_vld_n` and `lane_bit` are.
- R9: `pkt_bytes` counts the bytes delivered in the current packet, including a partial byte. It changes on the same edge as `byte_vld`, holds its value after the last byte, and reads 0 one clock after the next packet's start cycle.
- R10: `pkt_bytes` saturates at 255 and never wraps.
- R11: When `byte_vld`=0, `byte_data`, `byte_last` and `byte_len_err` are all 0.
- R12: An end cycle with `lane_vld_n`=1 and no pending bits delivers no byte. The last full byte already delivered keeps `byte_last`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_bit | input | 1 | Serial data bit of the lane |
| lane_vld_n | input | 1 | Lane valid strobe, active low |
| lane_frm_n | input | 1 | Lane frame strobe, active low |
| byte_vld | output | 1 | One-cycle pulse: a byte is delivered |
| byte_data | output | 8 | Delivered byte, first lane bit in bit 0 |
| byte_last | output | 1 | Byte holds the packet's final bit |
| byte_len_err | output | 1 | Final byte was partial and is zero-extended |
| pkt_bytes | output | 8 | Saturating count of bytes delivered in the current packet |

## Verification
The assertions check the following on every cycle:
- The output fields are quiet whenever no byte is delivered.
- A length error only ever comes with the last flag.
- No byte follows a last byte in the very next cycle.
- The byte count only steps up by one alongside a delivered byte, drops only to zero, and sticks at its maximum.
- The outputs are clean right after reset.

Some behaviours can only be shown by the bench's scenarios, because they depend on what was sent on the lane:
- bit order within a byte;
- capture of the final bit that arrives with frame high;
- skipping of valid-high gaps;
- zero padding of a partial byte;
- ignoring the lane after reset and between packets;
- the count being held after a packet and cleared at the next start.

// File: rtl/lane_rx_pkg.sv
package lane_rx_pkg;

    // Lane tracking states
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,  // after reset: wait until frame is seen high
        ST_IDLE  = 2'd1,  // between packets
        ST_RECV  = 2'd2   // inside a packet
    } rx_state_e;

endpackage

// File: rtl/lane_rx_ctrl.sv
module lane_rx_ctrl
    import lane_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frm_n,
    input  logic vld_n,
    output logic take,
    output logic pkt_start,
    output logic pkt_end
);

    rx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (frm_n)  state_d = ST_IDLE;
            ST_IDLE:  if (!frm_n) state_d = ST_RECV;
            ST_RECV:  if (frm_n)  state_d = ST_IDLE;
            default:              state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        take      = 1'b0;
        pkt_start = 1'b0;
        pkt_end   = 1'b0;
        unique case (state_q)
            ST_ARMED: ;
            ST_IDLE: begin
                if (!frm_n) begin
                    pkt_start = 1'b1;
                    take      = !vld_n;
                end
            end
            ST_RECV: begin
                take    = !vld_n;   // final bit arrives with frame already high
                pkt_end = frm_n;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lane_rx_packer.sv
module lane_rx_packer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              pkt_start,
    input  logic              pkt_end,
    input  logic              bit_in,
    output logic              emit,
    output logic [BYTE_W-1:0] emit_data,
    output logic              emit_last,
    output logic              emit_err
);

    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] acc_q, base_acc, merged;
    logic [IDX_W-1:0]  pos_q, base_pos;
    logic              full, pending;

    always_comb begin
        base_acc = pkt_start ? '0 : acc_q;
        base_pos = pkt_start ? '0 : pos_q;
        merged   = base_acc;
        if (take) merged[base_pos] = bit_in;
        full     = take && (base_pos == TOP_IDX);
        pending  = take || (base_pos != '0);
        emit      = full || (pkt_end && pending);
        emit_data = merged;
        emit_last = pkt_end && pending;
        emit_err  = pkt_end && pending && !full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || emit || pkt_end) begin
            acc_q <= '0;
            pos_q <= '0;
        end else begin
            acc_q <= merged;
            pos_q <= take ? IDX_W'(base_pos + 1'b1) : base_pos;
        end
    end

endmodule

// File: rtl/lane_rx_tally.sv
module lane_rx_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             emit,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (pkt_start) begin
            count <= emit ? CNT_W'(1) : '0;
        end else if (emit && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lane_byte_rx.sv
module lane_byte_rx #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_bit,
    input  logic              lane_vld_n,
    input  logic              lane_frm_n,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_last,
    output logic              byte_len_err,
    output logic [CNT_W-1:0]  pkt_bytes
);

    logic              take, pkt_start, pkt_end;
    logic              emit, emit_last, emit_err;
    logic [BYTE_W-1:0] emit_data;

    lane_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_n     (lane_frm_n),
        .vld_n     (lane_vld_n),
        .take      (take),
        .pkt_start (pkt_start),
        .pkt_end   (pkt_end)
    );

    lane_rx_packer #(.BYTE_W(BYTE_W)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .pkt_start (pkt_start),
        .pkt_end   (pkt_end),
        .bit_in    (lane_bit),
        .emit      (emit),
        .emit_data (emit_data),
        .emit_last (emit_last),
        .emit_err  (emit_err)
    );

    lane_rx_tally #(.CNT_W(CNT_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_start (pkt_start),
        .emit      (emit),
        .count     (pkt_bytes)
    );

    // registered byte interface, fields forced to zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld     <= 1'b0;
            byte_data    <= '0;
            byte_last    <= 1'b0;
            byte_len_err <= 1'b0;
        end else begin
            byte_vld     <= emit;
            byte_data    <= emit ? emit_data : '0;
            byte_last    <= emit && emit_last;
            byte_len_err <= emit && emit_err;
        end
    end

endmodule

// File: rtl/lane_byte_rx_chk.sv
module lane_byte_rx_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_data,
    input logic              byte_last,
    input logic              byte_len_err,
    input logic [CNT_W-1:0]  pkt_bytes
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!byte_vld && pkt_bytes == '0));

    // R11
    idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> (byte_data == '0 && !byte_last && !byte_len_err));

    // R6
    err_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_len_err |-> byte_last);

    // R4
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |=> !byte_vld);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bytes != $past(pkt_bytes) && pkt_bytes != '0)
            |-> (byte_vld && pkt_bytes == $past(pkt_bytes) + 1'b1));

    // R9
    byte_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> pkt_bytes != '0);

    // R10
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pkt_bytes) == CNT_MAX && pkt_bytes != '0) |-> pkt_bytes == CNT_MAX);

endmodule

bind lane_byte_rx lane_byte_rx_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (byte_vld),
    .byte_data    (byte_data),
    .byte_last    (byte_last),
    .byte_len_err (byte_len_err),
    .pkt_bytes    (pkt_bytes)
);

// File: tb/test_lane_byte_rx.sv
`timescale 1ns/1ps
module test_lane_byte_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lane_bit = 1'b0;
    logic       lane_vld_n = 1'b1;
    logic       lane_frm_n = 1'b1;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_last;
    logic       byte_len_err;
    logic [7:0] pkt_bytes;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] data;
        logic       last;
        logic       err;
        logic [7:0] cnt;
    } rx_byte_t;

    rx_byte_t got_q[$];

    always #2 clk = ~clk;

    lane_byte_rx i_lane_byte_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_bit     (lane_bit),
        .lane_vld_n   (lane_vld_n),
        .lane_frm_n   (lane_frm_n),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .byte_last    (byte_last),
        .byte_len_err (byte_len_err),
        .pkt_bytes    (pkt_bytes)
    );

    // monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            rx_byte_t e;
            e.data = byte_data;
            e.last = byte_last;
            e.err  = byte_len_err;
            e.cnt  = pkt_bytes;
            got_q.push_back(e);
        end
    end

    task automatic check_val(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(logic f, logic v, logic b);
        lane_frm_n = f;
        lane_vld_n = v;
        lane_bit   = b;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 1'b0);
    endtask

    task automatic send_packet(logic bits[$], int gap_every);
        int n = bits.size();
        for (int i = 0; i < n; i++) begin
            if (gap_every > 0 && i > 0 && (i % gap_every) == 0)
                tick(1'b0, 1'b1, 1'($urandom_range(0, 1)));
            tick((i == n - 1) ? 1'b1 : 1'b0, 1'b0, bits[i]);
        end
        idle(3);
    endtask

    task automatic expect_bytes(string req, logic bits[$]);
        int n     = bits.size();
        int rem   = n % 8;
        int total = n / 8 + ((rem != 0) ? 1 : 0);
        check_val({req, " byte count"}, got_q.size(), total);
        for (int k = 0; k < total; k++) begin
            logic [7:0] d = '0;
            rx_byte_t g;
            for (int j = 0; j < 8; j++)
                if (k * 8 + j < n) d[j] = bits[k * 8 + j];
            if (got_q.size() == 0) break;
            g = got_q.pop_front();
            check_val({req, " data"}, int'(g.data), int'(d));
            check_val({req, " last"}, int'(g.last), (k == total - 1) ? 1 : 0);
            check_val({req, " len_err"}, int'(g.err), (k == total - 1 && rem != 0) ? 1 : 0);
            check_val({req, " pkt_bytes"}, int'(g.cnt), (k + 1 > 255) ? 255 : k + 1);
        end
        got_q.delete();
    endtask

    function automatic void make_bits(ref logic bits[$], input int n, input logic [31:0] seed_pat);
        bits.delete();
        for (int i = 0; i < n; i++) bits.push_back(seed_pat[i % 32] ^ 1'($urandom_range(0, 1)));
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 byte_vld", int'(byte_vld), 0);
        check_val("R1 byte_data", int'(byte_data), 0);
        check_val("R1 pkt_bytes", int'(pkt_bytes), 0);
        idle(2);
        got_q.delete();
    endtask

    // R2 R3 R4: one byte, LSB first, final bit with frame high
    task automatic t_single_byte();
        logic b[$];
        logic [7:0] v = 8'hA5;
        for (int i = 0; i < 8; i++) b.push_back(v[i]);
        send_packet(b, 0);
        expect_bytes("R2 R3 R4 single 0xA5", b);
    endtask

    // R5: gaps with valid high inside the packet
    task automatic t_gaps();
        logic b[$];
        make_bits(b, 24, 32'h3C5A_0F96);
        send_packet(b, 3);
        expect_bytes("R5 gaps", b);
    endtask

    // R6: partial final byte
    task automatic t_partial();
        logic b[$];
        for (int i = 0; i < 11; i++) b.push_back(1'b1);
        send_packet(b, 0);
        expect_bytes("R6 partial 11 bits", b);
    endtask

    // R8: valid low while frame high between packets is ignored
    task automatic t_idle_noise();
        logic b[$];
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 1'b1);
        idle(2);
        check_val("R8 no byte from idle noise", got_q.size(), 0);
        make_bits(b, 16, 32'h1234_5678);
        send_packet(b, 0);
        expect_bytes("R8 packet after noise", b);
    endtask

    // R9: count held after packet and cleared by next start
    task automatic t_count_hold();
        logic b[$];
        make_bits(b, 24, 32'hDEAD_BEEF);
        send_packet(b, 0);
        idle(4);
        check_val("R9 pkt_bytes held", int'(pkt_bytes), 3);
        expect_bytes("R9 three bytes", b);
        tick(1'b0, 1'b1, 1'b0);          // start cycle, no data
        check_val("R9 pkt_bytes cleared", int'(pkt_bytes), 0);
        tick(1'b0, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b1);          // single final bit
        idle(3);
        b.delete();
        b.push_back(1'b1);
        expect_bytes("R9 R6 one-bit packet", b);
    endtask

    // R10: saturation
    task automatic t_saturate();
        logic b[$];
        make_bits(b, 300 * 8, 32'h0F0F_A5A5);
        send_packet(b, 0);
        check_val("R10 pkt_bytes saturated", int'(pkt_bytes), 255);
        expect_bytes("R10 long packet", b);
    endtask

    // R12: end cycle without data and nothing pending
    task automatic t_empty_end();
        logic [7:0] v = 8'h6E;
        rx_byte_t g;
        for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, v[i]);
        tick(1'b1, 1'b1, 1'b0);
        idle(3);
        check_val("R12 bytes delivered", got_q.size(), 1);
        if (got_q.size() > 0) begin
            g = got_q.pop_front();
            check_val("R12 data", int'(g.data), int'(v));
            check_val("R12 last stays 0", int'(g.last), 0);
            check_val("R12 len_err", int'(g.err), 0);
        end
        got_q.delete();
    endtask

    // R7: reset released mid-packet, lane ignored until frame high
    task automatic t_armed();
        logic b[$];
        lane_frm_n = 1'b0;
        lane_vld_n = 1'b0;
        lane_bit   = 1'b1;
        rst_n      = 1'b0;
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b1);
        idle(3);
        check_val("R7 no byte while armed", got_q.size(), 0);
        check_val("R7 pkt_bytes", int'(pkt_bytes), 0);
        check_val("R11 byte_data idle", int'(byte_data), 0);
        make_bits(b, 8, 32'h8181_8181);
        send_packet(b, 0);
        expect_bytes("R7 packet after arm", b);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_byte();
        t_gaps();
        t_partial();
        t_idle_noise();
        t_count_hold();
        t_empty_end();
        t_saturate();
        t_armed();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule